// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets synchronous logic use an external asynchronous static RAM that is one byte wide and has 17 address bits. On the user side it takes single read or write requests through a valid/ready handshake. Read results come back on a data port together with a one-cycle valid strobe. On the memory side it drives the address, the active-low chip-select, write-enable and output-enable pins, and a data bus split into an output value, an output enable and an input value.

The RAM's timing is expressed as clock-cycle counts set by parameters. These are the write pulse width, the read access time and the bus turnaround after a read. Writes are ended by the write-enable pin, and output enable stays inactive throughout. The controller only drives the bus while the RAM's output stage is off. When no request is in progress, chip select is high, so the RAM sits in standby.

Top module: `sram_ctl`

## Requirements
- R1: A synchronous reset (rst high) returns the block to idle. In the cycle after reset, ramCsN, ramWeN and ramOeN are 1, ramDoe is 0, rdValid is 0 and reqReady is 1.
- R2: While reqReady is 1 (idle), ramCsN is 1.
- R3: A write is accepted on a clock edge where reqValid, reqReady and reqWrite are all 1. From the next cycle, ramCsN and ramWeN are both 0 for exactly WR_CYC cycles. ramOeN stays 1 for the whole write.
- R4: In every cycle where ramCsN is 0, ramAddr holds the accepted address unchanged. During a write, ramDout holds the accepted data from the cycle ramWeN falls through the cycle after it rises.
- R5: ramDoe is 1 from the cycle ramWeN goes to 0 until one cycle after ramWeN returns to 1, and is 0 in all other cycles.
- R6: A read is accepted when reqValid and reqReady are 1 and reqWrite is 0. From the next cycle, ramCsN and ramOeN are 0 and ramWeN is 1 for exactly RD_CYC cycles.
- R7: ramDin is sampled at the clock edge that ends the last access cycle. rdData then carries that byte while rdValid is 1 for exactly one cycle, the cycle after that edge.
- R8: After a read, reqReady stays 0 for TURN_CYC cycles after the access ends (at least one idle cycle before any write). After a write, reqReady is 0 for WR_CYC+1 cycles.
- R9: ramDoe is never 1 in a cycle where ramOeN is 0, so the bus never has two drivers.
- R10: A byte written to an address is returned by a later read of that address, for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| rdValid | output | 1 | Read data valid, one-cycle pulse |
| rdData | output | DATA_W | Read data |
| ramAddr | output | ADDR_W | RAM address pins |
| ramCsN | output | 1 | RAM chip select, active low |
| ramWeN | output | 1 | RAM write enable, active low |
| ramOeN | output | 1 | RAM output enable, active low |
| ramDout | output | DATA_W | Value driven onto the RAM data bus |
| ramDoe | output | 1 | Drive enable for the RAM data bus |
| ramDin | input | DATA_W | Value read from the RAM data bus |

## Verification
The bench uses a 64-word configuration with unequal cycle counts, so that a count applied to the wrong phase shows up. It writes every address with one arithmetic pattern and reads all of them back. This separates address decoding errors from data path errors. It then runs back-to-back write/read pairs with a second pattern on every address. These pairs exercise the turnaround after a read and check that an overwrite replaces the old byte. For every operation the bench counts the cycles spent in each pin phase, and at every cycle it watches for bus contention.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_WREC,
    ST_READ,
    ST_TURN
  } ctlState_t;

  typedef struct packed {
    logic loadReq;
    logic capRd;
  } ctlStrobe_t;

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int WR_CYC   = 1,
  parameter int RD_CYC   = 1,
  parameter int TURN_CYC = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output ctlStrobe_t strobe,
  output logic       ramCsN,
  output logic       ramWeN,
  output logic       ramOeN,
  output logic       ramDoe
);

  localparam int MAXC  = (WR_CYC > RD_CYC) ?
                         ((WR_CYC > TURN_CYC) ? WR_CYC : TURN_CYC) :
                         ((RD_CYC > TURN_CYC) ? RD_CYC : TURN_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);

  ctlState_t        state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stateNext      = state;
    cntNext        = cnt;
    strobe.loadReq = 1'b0;
    strobe.capRd   = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          if (reqWrite) begin
            stateNext = ST_WRITE;
            cntNext   = CNT_W'(WR_CYC - 1);
          end else begin
            stateNext = ST_READ;
            cntNext   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_WRITE: begin
        if (cnt == '0) stateNext = ST_WREC;
        else           cntNext   = cnt - 1'b1;
      end
      ST_WREC: stateNext = ST_IDLE;
      ST_READ: begin
        if (cnt == '0) begin
          strobe.capRd = 1'b1;
          stateNext    = ST_TURN;
          cntNext      = CNT_W'(TURN_CYC - 1);
        end else begin
          cntNext = cnt - 1'b1;
        end
      end
      ST_TURN: begin
        if (cnt == '0) stateNext = ST_IDLE;
        else           cntNext   = cnt - 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      ramCsN <= 1'b1;
      ramWeN <= 1'b1;
      ramOeN <= 1'b1;
      ramDoe <= 1'b0;
    end else begin
      state  <= stateNext;
      cnt    <= cntNext;
      ramCsN <= !(stateNext == ST_WRITE || stateNext == ST_READ);
      ramWeN <= !(stateNext == ST_WRITE);
      ramOeN <= !(stateNext == ST_READ);
      ramDoe <= (stateNext == ST_WRITE || stateNext == ST_WREC);
    end
  end

  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ramDin,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramDout,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ramAddr <= '0;
      ramDout <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      if (strobe.loadReq) begin
        ramAddr <= reqAddr;
        ramDout <= reqWdata;
      end
      if (strobe.capRd) rdData <= ramDin;
      rdValid <= strobe.capRd;
    end
  end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int WR_CYC   = 1,
  parameter int RD_CYC   = 1,
  parameter int TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramCsN,
  output logic              ramWeN,
  output logic              ramOeN,
  output logic [DATA_W-1:0] ramDout,
  output logic              ramDoe,
  input  logic [DATA_W-1:0] ramDin
);

  ctlStrobe_t strobe;

  sram_ctl_fsm #(
    .WR_CYC(WR_CYC), .RD_CYC(RD_CYC), .TURN_CYC(TURN_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .strobe(strobe), .ramCsN(ramCsN),
    .ramWeN(ramWeN), .ramOeN(ramOeN), .ramDoe(ramDoe)
  );

  sram_ctl_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .ramDin(ramDin), .ramAddr(ramAddr),
    .ramDout(ramDout), .rdValid(rdValid), .rdData(rdData)
  );

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reqReady,
  input logic              rdValid,
  input logic [ADDR_W-1:0] ramAddr,
  input logic              ramCsN,
  input logic              ramWeN,
  input logic              ramOeN,
  input logic [DATA_W-1:0] ramDout,
  input logic              ramDoe
);

  a_r1_reset_pins: assert property (@(posedge clk)
    rst |=> (ramCsN && ramWeN && ramOeN && !ramDoe && !rdValid && reqReady));

  a_r2_idle_deselect: assert property (@(posedge clk) disable iff (rst)
    reqReady |-> ramCsN);

  a_r3_write_oe_off: assert property (@(posedge clk) disable iff (rst)
    !ramWeN |-> (!ramCsN && ramOeN));

  a_r4_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!ramCsN && !$past(ramCsN)) |-> $stable(ramAddr));

  a_r4_wrec_stable: assert property (@(posedge clk) disable iff (rst)
    $rose(ramWeN) |-> ($stable(ramAddr) && $stable(ramDout)));

  a_r5_drive_window: assert property (@(posedge clk) disable iff (rst)
    !ramWeN |-> ramDoe);

  a_r5_drive_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(ramWeN) |-> ramDoe);

  a_r6_read_pins: assert property (@(posedge clk) disable iff (rst)
    !ramOeN |-> (!ramCsN && ramWeN));

  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rdValid |=> !rdValid);

  a_r8_turnaround: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> !reqReady);

  a_r9_no_contention: assert property (@(posedge clk) disable iff (rst)
    ramDoe |-> ramOeN);

endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reqReady(reqReady), .rdValid(rdValid),
  .ramAddr(ramAddr), .ramCsN(ramCsN), .ramWeN(ramWeN), .ramOeN(ramOeN),
  .ramDout(ramDout), .ramDoe(ramDoe)
);

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

  localparam int AW   = 6;
  localparam int DW   = 8;
  localparam int WR   = 2;
  localparam int RD   = 3;
  localparam int TURN = 2;
  localparam int NW   = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          rdValid;
  logic [DW-1:0] rdData;
  logic [AW-1:0] ramAddr;
  logic          ramCsN, ramWeN, ramOeN, ramDoe;
  logic [DW-1:0] ramDout;
  logic [DW-1:0] ramDin;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 0;

  always #5 clk = ~clk;

  sram_ctl #(
    .ADDR_W(AW), .DATA_W(DW), .WR_CYC(WR), .RD_CYC(RD), .TURN_CYC(TURN)
  ) u_sram_ctl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .ramAddr(ramAddr),
    .ramCsN(ramCsN), .ramWeN(ramWeN), .ramOeN(ramOeN),
    .ramDout(ramDout), .ramDoe(ramDoe), .ramDin(ramDin)
  );

  // RAM model: write captured when the write window closes
  logic [DW-1:0] mem [NW];
  logic          pCs = 1'b1, pWe = 1'b1, pDoe = 1'b0;
  logic [AW-1:0] pAddr = '0;
  logic [DW-1:0] pDout = '0;

  assign ramDin = (!ramCsN && ramWeN && !ramOeN) ? mem[ramAddr] : 8'hEE;

  always @(negedge clk) begin
    if (!pCs && !pWe && (ramCsN || ramWeN))
      mem[pAddr] = pDoe ? pDout : 8'hXX;
    pCs = ramCsN; pWe = ramWeN; pDoe = ramDoe; pAddr = ramAddr; pDout = ramDout;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R9: contention watch on every cycle once out of reset
  always @(negedge clk)
    if (!rst && ramDoe && !ramOeN) chk(0, "R9 contention", 1, 0);

  function automatic logic [DW-1:0] pat1(input int a);
    return DW'((a * 37 + 5) & 255);
  endfunction
  function automatic logic [DW-1:0] pat2(input int a);
    return DW'((a * 91 + 200) & 255);
  endfunction

  task automatic issue(input bit w, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = AW'(a); reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doWrite(input int a, input logic [DW-1:0] d);
    int lowCnt = 0;
    bit ok = 1;
    issue(1'b1, a, d);
    while (!ramWeN && lowCnt < 20) begin
      if (ramCsN || !ramOeN || !ramDoe || ramAddr != AW'(a) || ramDout != d) ok = 0;
      if (reqReady) ok = 0;
      lowCnt++;
      @(negedge clk);
    end
    chk(lowCnt == WR, "R3 write pulse cycles", lowCnt, WR);
    chk(ok, "R4 R5 R2 pins during write", 0, 1);
    chk(ramDoe && ramCsN && ramOeN && !reqReady && ramDout == d,
        "R5 drive held one cycle after write", int'(ramDoe), 1);
    @(negedge clk);
    chk(reqReady && !ramDoe && ramCsN, "R8 R2 ready after write", int'(reqReady), 1);
  endtask

  task automatic doRead(input int a, input logic [DW-1:0] exp);
    int lowCnt = 0;
    int busy = 0;
    bit ok = 1;
    issue(1'b0, a, 8'h00);
    while (!ramOeN && lowCnt < 20) begin
      if (ramCsN || !ramWeN || ramDoe || rdValid || ramAddr != AW'(a)) ok = 0;
      lowCnt++;
      @(negedge clk);
    end
    chk(lowCnt == RD, "R6 read access cycles", lowCnt, RD);
    chk(ok, "R6 R4 pins during read", 0, 1);
    chk(rdValid && rdData == exp, "R7 R10 read data", int'(rdData), int'(exp));
    while (!reqReady && busy < 20) begin
      busy++;
      @(negedge clk);
      if (busy == 1) chk(!rdValid, "R7 single valid pulse", int'(rdValid), 0);
    end
    chk(busy == TURN, "R8 turnaround cycles", busy, TURN);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ramCsN && ramWeN && ramOeN && !ramDoe && !rdValid && reqReady,
        "R1 reset state", {28'd0, ramCsN, ramWeN, ramOeN, ramDoe}, 14);
    repeat (3) @(negedge clk);
    chk(ramCsN && reqReady, "R2 idle deselect", int'(ramCsN), 1);

    // R10 full sweep: write all, then read all
    for (int a = 0; a < NW; a++) doWrite(a, pat1(a));
    for (int a = 0; a < NW; a++) doRead(a, pat1(a));
    // overwrite with write-read pairs (read then write crosses turnaround)
    for (int a = NW - 1; a >= 0; a--) begin
      doWrite(a, pat2(a));
      doRead(a, pat2(a));
    end
    // reset mid-idle again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(ramCsN && ramWeN && ramOeN && !ramDoe && reqReady, "R1 second reset",
        int'(reqReady), 1);
    doRead(5, pat2(5));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule